// File: doc/BRIEF.md
# Synonym-Resolving Tag Lookup for a Virtually Indexed Data Cache

This unit is the tag-lookup and fill-control stage of a small four-way L1 data cache. The set is chosen from virtual address bits, but each stored tag is a physical page number. One way is larger than a page, so the top index bits lie above the page offset. A single physical line could therefore be reached through several different sets, called alias sets. The unit makes sure such a line exists in only one place. Seen from outside, the cache then acts like a physically indexed cache with twice as many ways (32 KB) or four times as many ways (64 KB).

A request carries the virtual address and the translated physical address, which arrive together. The unit first probes the set named by the virtual address. If the line is not there, it probes the other alias sets, one per cycle. The outcome is one of three:
- a hit;
- a synonym, where the line is moved out of another alias set into the requested set together with its dirty state;
- a miss, which allocates a way and raises a fill request.

When a dirty line is displaced, the unit reports a write-back address. The data array, the coherence protocol and the real translation are outside this unit.

Top module: `vipt_synonym_lookup`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, fill_valid and evict_valid are 0, and every line is invalid, so the first access to any address is a miss.
- R2: If the request's physical page number is valid in the set given by virtual address bits [12:6], the response is HIT (rsp_kind code 0). It comes after one probe cycle, and rsp_way gives the matching way.
- R3: If the first probe misses, the other alias sets are probed one per cycle. Probe k reads the set whose alias bits are the virtual alias bits XOR k. A synonym found at probe k responds after k+1 probe cycles, and a miss responds after all alias sets have been probed (2 with the default size).
- R4: A line found in another alias set gives SYNONYM (code 1). That copy is invalidated, and the line is installed in the requested set in the same cycle. A physical line is therefore never valid in two places at once.
- R5: A request with req_write=1 leaves the line dirty, whether it hits, moves or is allocated. A moved line keeps its dirty state.
- R6: A miss gives MISS (code 2). In the same cycle, fill_valid pulses and fill_paddr carries the request's physical address with bits [5:0] cleared.
- R7: On a move or an allocation, the way is the lowest-numbered invalid way of the requested set. If all ways are valid, a per-set 3-bit tree pseudo-LRU picks the way.
- R8: If the chosen way held a valid dirty line, evict_valid pulses with the response, and evict_paddr gives that line's physical line address. Displacing a clean line does not raise evict_valid.
- R9: req_ready drops in the cycle after a request is accepted and stays low until the response cycle. rsp_valid is high for exactly one cycle per request.
- R10: Every hit, move and allocation updates the pseudo-LRU of the requested set to point away from the way it used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit is idle and will take a request |
| req_vaddr | input | VA_W | Virtual address (selects the set) |
| req_paddr | input | PA_W | Translated physical address |
| req_write | input | 1 | Request is a store, so the line becomes dirty |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | 0 hit, 1 synonym moved, 2 miss allocated |
| rsp_way | output | 2 | Way used in the requested set |
| fill_valid | output | 1 | Line fill request (with a miss) |
| fill_paddr | output | PA_W | Physical line address to fill |
| evict_valid | output | 1 | A dirty line was displaced |
| evict_paddr | output | PA_W | Physical line address of the displaced dirty line |

## Verification
The hardest state to reach is a dirty line that has been moved between alias sets and is later pushed out by replacement. Reaching it needs two virtual pages mapped to one physical page and a store through one of them. The line then has to be bounced back and forth between the two sets, and each bounce must report a synonym rather than a hit, which shows no stale copy was left behind. After that, enough misses go to the same set to fill its invalid ways and steer the pseudo-LRU back onto the moved line. The eviction address seen at the ports then shows that the dirty state travelled with the line.

// File: rtl/vipt_pkg.sv
// Shared types for the synonym-resolving tag lookup.
// Assumes: response codes are decoded by the data path with these values.
package vipt_pkg;
    typedef enum logic [1:0] {
        RSP_HIT  = 2'd0,
        RSP_SYN  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_kind_e;
endpackage

// File: rtl/vipt_tag_store.sv
// Tag, valid and dirty storage for all sets and ways.
// Two combinational read ports (probe set and home set), one invalidate
// port and one install port. Assumes invalidate and install never target
// the same set in one cycle.
module vipt_tag_store #(
    parameter int SETS     = 128,
    parameter int IDX_W    = 7,
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2,
    parameter int TAG_W    = 20
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [IDX_W-1:0]                   prb_set,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]     prb_tag,
    output logic [NUM_WAYS-1:0]                prb_valid,
    output logic [NUM_WAYS-1:0]                prb_dirty,
    input  logic [IDX_W-1:0]                   home_set,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]     home_tag,
    output logic [NUM_WAYS-1:0]                home_valid,
    output logic [NUM_WAYS-1:0]                home_dirty,
    input  logic                               inv_en,
    input  logic [IDX_W-1:0]                   inv_set,
    input  logic [WAY_W-1:0]                   inv_way,
    input  logic                               ins_en,
    input  logic [IDX_W-1:0]                   ins_set,
    input  logic [WAY_W-1:0]                   ins_way,
    input  logic [TAG_W-1:0]                   ins_tag,
    input  logic                               ins_dirty
);
    logic [TAG_W-1:0]    tag_q   [SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0] valid_q [SETS];
    logic [NUM_WAYS-1:0] dirty_q [SETS];

    // Read both ports combinationally from the flop arrays.
    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            prb_tag[w]  = tag_q[prb_set][w];
            home_tag[w] = tag_q[home_set][w];
        end
        prb_valid  = valid_q[prb_set];
        prb_dirty  = dirty_q[prb_set];
        home_valid = valid_q[home_set];
        home_dirty = dirty_q[home_set];
    end

    // State bits: cleared by reset, then invalidate and install updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            if (inv_en) begin
                valid_q[inv_set][inv_way] <= 1'b0;
                dirty_q[inv_set][inv_way] <= 1'b0;
            end
            if (ins_en) begin
                valid_q[ins_set][ins_way] <= 1'b1;
                dirty_q[ins_set][ins_way] <= ins_dirty;
            end
        end
    end

    // Tag payload: written on install only, no reset needed.
    always_ff @(posedge clk) begin
        if (ins_en) tag_q[ins_set][ins_way] <= ins_tag;
    end

    // Checker view: another way of the install set already holds this tag.
    logic dup_other;
    always_comb begin
        dup_other = 1'b0;
        for (int w = 0; w < NUM_WAYS; w++)
            if (WAY_W'(w) != ins_way && valid_q[ins_set][w] && tag_q[ins_set][w] == ins_tag)
                dup_other = 1'b1;
    end

    AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !dup_other);  // R4
    AST_MOVE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && ins_en) |-> (inv_set != ins_set));  // R4
endmodule

// File: rtl/vipt_plru.sv
// Per-set 3-bit tree pseudo-LRU for four ways.
// Bit 0 selects the pair (1 = upper pair), bit 1 picks inside ways 0/1,
// bit 2 picks inside ways 2/3. An update points the tree away from a way.
module vipt_plru #(
    parameter int SETS  = 128,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_set,
    output logic [1:0]       victim,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_set,
    input  logic [1:0]       upd_way
);
    logic [2:0] tree_q [SETS];

    function automatic logic [1:0] pick(input logic [2:0] t);
        if (t[0]) return t[2] ? 2'd3 : 2'd2;
        else      return t[1] ? 2'd1 : 2'd0;
    endfunction

    function automatic logic [2:0] touch(input logic [2:0] t, input logic [1:0] w);
        logic [2:0] n;
        n = t;
        n[0] = ~w[1];
        if (w[1]) n[2] = ~w[0];
        else      n[1] = ~w[0];
        return n;
    endfunction

    // Victim lookup for the set being filled.
    always_comb victim = pick(tree_q[rd_set]);

    // Tree state update on every access of a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (upd_en) begin
            tree_q[upd_set] <= touch(tree_q[upd_set], upd_way);
        end
    end

    // Checker copy of the last update, to look at the tree one cycle later.
    logic             chk_en_q;
    logic [IDX_W-1:0] chk_set_q;
    logic [1:0]       chk_way_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_en_q  <= 1'b0;
            chk_set_q <= '0;
            chk_way_q <= '0;
        end else begin
            chk_en_q  <= upd_en;
            chk_set_q <= upd_set;
            chk_way_q <= upd_way;
        end
    end

    AST_PLRU_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en_q |-> (pick(tree_q[chk_set_q]) != chk_way_q));  // R10
endmodule

// File: rtl/vipt_lookup_ctrl.sv
// Probe sequencer and fill control. Accepts one request at a time, probes
// the home set and then the other alias sets, and decides hit, synonym
// move or miss allocation. Assumes the tag store reads are combinational.
module vipt_lookup_ctrl
    import vipt_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PA_W     = 32,
    parameter int OFF_W    = 6,
    parameter int IDX_W    = 7,
    parameter int ALIAS_W  = 1,
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2,
    parameter int TAG_W    = 20
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [VA_W-1:0]                req_vaddr,
    input  logic [PA_W-1:0]                req_paddr,
    input  logic                           req_write,
    output logic [IDX_W-1:0]               prb_set,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] prb_tag,
    input  logic [NUM_WAYS-1:0]            prb_valid,
    input  logic [NUM_WAYS-1:0]            prb_dirty,
    output logic [IDX_W-1:0]               home_set,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] home_tag,
    input  logic [NUM_WAYS-1:0]            home_valid,
    input  logic [NUM_WAYS-1:0]            home_dirty,
    input  logic [WAY_W-1:0]               plru_victim,
    output logic                           plru_upd,
    output logic [WAY_W-1:0]               plru_way,
    output logic                           inv_en,
    output logic [IDX_W-1:0]               inv_set,
    output logic [WAY_W-1:0]               inv_way,
    output logic                           ins_en,
    output logic [IDX_W-1:0]               ins_set,
    output logic [WAY_W-1:0]               ins_way,
    output logic [TAG_W-1:0]               ins_tag,
    output logic                           ins_dirty,
    output logic                           rsp_valid,
    output rsp_kind_e                      rsp_kind,
    output logic [WAY_W-1:0]               rsp_way,
    output logic                           fill_valid,
    output logic [PA_W-1:0]                fill_paddr,
    output logic                           evict_valid,
    output logic [PA_W-1:0]                evict_paddr
);
    localparam int LINE_W = PA_W - OFF_W;
    localparam int LOW_W  = IDX_W - ALIAS_W;
    localparam logic [ALIAS_W-1:0] LAST_PROBE = ALIAS_W'((1 << ALIAS_W) - 1);

    typedef enum logic {ST_IDLE, ST_PROBE} state_e;

    state_e             state_q;
    logic [ALIAS_W-1:0] probe_q;
    logic [IDX_W-1:0]   va_idx_q;
    logic [LINE_W-1:0]  pa_line_q;
    logic               write_q;

    logic unused_addr;
    assign unused_addr = ^{req_vaddr[VA_W-1:OFF_W+IDX_W], req_vaddr[OFF_W-1:0], req_paddr[OFF_W-1:0]};

    logic [TAG_W-1:0]    ppn;
    logic [NUM_WAYS-1:0] match;
    logic                found;
    logic [WAY_W-1:0]    hit_way;
    logic [WAY_W-1:0]    victim;
    logic                decide;
    rsp_kind_e           dec_kind;
    logic [WAY_W-1:0]    dec_way;

    assign req_ready = (state_q == ST_IDLE);
    assign ppn       = pa_line_q[LINE_W-1 -: TAG_W];
    assign home_set  = va_idx_q;
    assign prb_set   = {va_idx_q[IDX_W-1 -: ALIAS_W] ^ probe_q, va_idx_q[LOW_W-1:0]};

    // Physical tag compare on the set being probed.
    always_comb begin
        hit_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            match[w] = prb_valid[w] && (prb_tag[w] == ppn);
            if (match[w]) hit_way = WAY_W'(w);
        end
        found = |match;
    end

    // Way choice in the home set: lowest invalid way, else pseudo-LRU.
    always_comb begin
        victim = plru_victim;
        for (int w = NUM_WAYS - 1; w >= 0; w--)
            if (!home_valid[w]) victim = WAY_W'(w);
    end

    // Outcome of the current probe cycle and the store writes it causes.
    always_comb begin
        decide    = (state_q == ST_PROBE) && (found || probe_q == LAST_PROBE);
        dec_kind  = RSP_MISS;
        dec_way   = victim;
        inv_en    = 1'b0;
        inv_set   = prb_set;
        inv_way   = hit_way;
        ins_en    = decide;
        ins_set   = home_set;
        ins_tag   = ppn;
        ins_dirty = write_q;
        if (found && probe_q == '0) begin
            dec_kind  = RSP_HIT;
            dec_way   = hit_way;
            ins_dirty = write_q | prb_dirty[hit_way];
        end else if (found) begin
            dec_kind  = RSP_SYN;
            inv_en    = decide;
            ins_dirty = write_q | prb_dirty[hit_way];
        end
        ins_way  = dec_way;
        plru_upd = decide;
        plru_way = dec_way;
    end

    // Request capture, probe stepping and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            probe_q     <= '0;
            va_idx_q    <= '0;
            pa_line_q   <= '0;
            write_q     <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_kind    <= RSP_HIT;
            rsp_way     <= '0;
            fill_valid  <= 1'b0;
            fill_paddr  <= '0;
            evict_valid <= 1'b0;
            evict_paddr <= '0;
        end else begin
            rsp_valid   <= 1'b0;
            fill_valid  <= 1'b0;
            evict_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q   <= ST_PROBE;
                        probe_q   <= '0;
                        va_idx_q  <= req_vaddr[OFF_W +: IDX_W];
                        pa_line_q <= req_paddr[PA_W-1:OFF_W];
                        write_q   <= req_write;
                    end
                end
                ST_PROBE: begin
                    if (decide) begin
                        state_q     <= ST_IDLE;
                        rsp_valid   <= 1'b1;
                        rsp_kind    <= dec_kind;
                        rsp_way     <= dec_way;
                        fill_valid  <= (dec_kind == RSP_MISS);
                        fill_paddr  <= {pa_line_q, {OFF_W{1'b0}}};
                        evict_valid <= (dec_kind != RSP_HIT) && home_valid[victim] && home_dirty[victim];
                        evict_paddr <= {home_tag[victim], va_idx_q[LOW_W-1:0], {OFF_W{1'b0}}};
                    end else begin
                        probe_q <= probe_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);  // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);  // R9
    AST_FILL_WITH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (rsp_valid && rsp_kind == RSP_MISS));  // R6
    AST_EVICT_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (rsp_valid && rsp_kind != RSP_HIT));  // R8
endmodule

// File: rtl/vipt_synonym_lookup.sv
// Top of the synonym-resolving tag lookup: wires the probe sequencer to
// the tag store and the replacement state. Assumes four ways, 4 KB pages
// and a cache large enough to have at least one alias bit.
module vipt_synonym_lookup
    import vipt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int CACHE_KB   = 32,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [PA_W-1:0] req_paddr,
    input  logic            req_write,
    output logic            rsp_valid,
    output logic [1:0]      rsp_kind,
    output logic [1:0]      rsp_way,
    output logic            fill_valid,
    output logic [PA_W-1:0] fill_paddr,
    output logic            evict_valid,
    output logic [PA_W-1:0] evict_paddr
);
    localparam int NUM_WAYS  = 4;
    localparam int WAY_W     = 2;
    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int PG_W      = $clog2(PAGE_BYTES);
    localparam int WAY_BYTES = CACHE_KB * 1024 / NUM_WAYS;
    localparam int SETS      = WAY_BYTES / LINE_BYTES;
    localparam int IDX_W     = $clog2(SETS);
    localparam int ALIAS_W   = IDX_W - (PG_W - OFF_W);
    localparam int TAG_W     = PA_W - PG_W;

    logic [IDX_W-1:0]               prb_set, home_set, inv_set, ins_set;
    logic [NUM_WAYS-1:0][TAG_W-1:0] prb_tag, home_tag;
    logic [NUM_WAYS-1:0]            prb_valid, prb_dirty, home_valid, home_dirty;
    logic [WAY_W-1:0]               plru_victim, plru_way, inv_way, ins_way, way_o;
    logic                           plru_upd, inv_en, ins_en, ins_dirty;
    logic [TAG_W-1:0]               ins_tag;
    rsp_kind_e                      kind_o;

    assign rsp_kind = kind_o;
    assign rsp_way  = way_o;

    vipt_tag_store #(
        .SETS(SETS), .IDX_W(IDX_W), .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .prb_set(prb_set), .prb_tag(prb_tag), .prb_valid(prb_valid), .prb_dirty(prb_dirty),
        .home_set(home_set), .home_tag(home_tag), .home_valid(home_valid), .home_dirty(home_dirty),
        .inv_en(inv_en), .inv_set(inv_set), .inv_way(inv_way),
        .ins_en(ins_en), .ins_set(ins_set), .ins_way(ins_way), .ins_tag(ins_tag),
        .ins_dirty(ins_dirty)
    );

    vipt_plru #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
        .clk(clk), .rst_n(rst_n),
        .rd_set(home_set), .victim(plru_victim),
        .upd_en(plru_upd), .upd_set(home_set), .upd_way(plru_way)
    );

    vipt_lookup_ctrl #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ALIAS_W(ALIAS_W),
        .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_paddr(req_paddr), .req_write(req_write),
        .prb_set(prb_set), .prb_tag(prb_tag), .prb_valid(prb_valid), .prb_dirty(prb_dirty),
        .home_set(home_set), .home_tag(home_tag), .home_valid(home_valid), .home_dirty(home_dirty),
        .plru_victim(plru_victim), .plru_upd(plru_upd), .plru_way(plru_way),
        .inv_en(inv_en), .inv_set(inv_set), .inv_way(inv_way),
        .ins_en(ins_en), .ins_set(ins_set), .ins_way(ins_way), .ins_tag(ins_tag),
        .ins_dirty(ins_dirty),
        .rsp_valid(rsp_valid), .rsp_kind(kind_o), .rsp_way(way_o),
        .fill_valid(fill_valid), .fill_paddr(fill_paddr),
        .evict_valid(evict_valid), .evict_paddr(evict_paddr)
    );
endmodule

// File: tb/vipt_synonym_lookup_test.sv
// Directed bench: two virtual pages share one physical page, a line is
// written, bounced between alias sets and finally evicted by replacement.
module vipt_synonym_lookup_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_paddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [1:0]  rsp_way;
    logic        fill_valid;
    logic [31:0] fill_paddr;
    logic        evict_valid;
    logic [31:0] evict_paddr;

    int tests_run = 0;
    int tests_failed = 0;

    localparam logic [1:0] K_HIT = 2'd0, K_SYN = 2'd1, K_MISS = 2'd2;
    localparam logic [31:0] VA_A = 32'h0000_1040;  // alias bit 1, set 65
    localparam logic [31:0] VA_B = 32'h0000_0040;  // alias bit 0, set 1
    localparam logic [31:0] PA_X = 32'h0008_5040;

    always #5 clk = ~clk;

    vipt_synonym_lookup uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_paddr(req_paddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_way(rsp_way),
        .fill_valid(fill_valid), .fill_paddr(fill_paddr),
        .evict_valid(evict_valid), .evict_paddr(evict_paddr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    // One request; checks outcome, way, latency, fill and eviction.
    task automatic access(input string req, input logic [31:0] va, input logic [31:0] pa,
                          input logic wr, input logic [1:0] exp_kind, input logic [1:0] exp_way,
                          input int exp_probes, input logic exp_evict, input logic [31:0] exp_epa);
        int probes;
        @(negedge clk);
        req_vaddr = va; req_paddr = pa; req_write = wr; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " R9 busy"}, 32'(req_ready), 32'd0);
        probes = 0;
        while (!rsp_valid && probes < 20) begin
            probes++;
            @(negedge clk);
        end
        chk({req, " R3 probes"}, 32'(probes), 32'(exp_probes));
        chk({req, " kind"}, 32'(rsp_kind), 32'(exp_kind));
        chk({req, " R7 way"}, 32'(rsp_way), 32'(exp_way));
        chk({req, " R6 fill"}, 32'(fill_valid), 32'(exp_kind == K_MISS));
        if (exp_kind == K_MISS) chk({req, " R6 fill addr"}, fill_paddr, {pa[31:6], 6'b0});
        chk({req, " R8 evict"}, 32'(evict_valid), 32'(exp_evict));
        if (exp_evict) chk({req, " R8 evict addr"}, evict_paddr, exp_epa);
        chk({req, " R9 ready"}, 32'(req_ready), 32'd1);
        @(negedge clk);
        chk({req, " R9 pulse"}, 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 rsp", 32'(rsp_valid), 32'd0);
        chk("R1 fill", 32'(fill_valid), 32'd0);
        chk("R1 evict", 32'(evict_valid), 32'd0);
    endtask

    task automatic t_synonym_bounce();
        access("R1 cold miss", VA_A, PA_X, 1'b0, K_MISS, 2'd0, 2, 1'b0, '0);
        access("R2 R5 write hit", VA_A, PA_X, 1'b1, K_HIT, 2'd0, 1, 1'b0, '0);
        access("R4 move to B", VA_B, PA_X, 1'b0, K_SYN, 2'd0, 2, 1'b0, '0);
        access("R2 hit B", VA_B, PA_X, 1'b0, K_HIT, 2'd0, 1, 1'b0, '0);
        access("R4 move to A", VA_A, PA_X, 1'b0, K_SYN, 2'd0, 2, 1'b0, '0);
        access("R4 move to B again", VA_B, PA_X, 1'b0, K_SYN, 2'd0, 2, 1'b0, '0);
    endtask

    task automatic t_replacement();
        access("R7 invalid way1", VA_B, 32'h0010_0040, 1'b0, K_MISS, 2'd1, 2, 1'b0, '0);
        access("R7 invalid way2", VA_B, 32'h0011_0040, 1'b0, K_MISS, 2'd2, 2, 1'b0, '0);
        access("R7 invalid way3", VA_B, 32'h0012_0040, 1'b0, K_MISS, 2'd3, 2, 1'b0, '0);
        access("R5 R8 R10 dirty evict", VA_B, 32'h0013_0040, 1'b0, K_MISS, 2'd0, 2, 1'b1, PA_X);
        access("R8 R10 clean evict", 32'h0000_0047, 32'h0014_0047, 1'b0, K_MISS, 2'd2, 2, 1'b0, '0);
        access("R4 evicted line gone", VA_A, PA_X, 1'b0, K_MISS, 2'd0, 2, 1'b0, '0);
    endtask

    initial begin
        t_reset();
        t_synonym_bounce();
        t_replacement();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule